// File: doc/BRIEF.md
# Single-Pass Blob Labeler

This block finds connected foreground regions in a binary image while the image streams past in raster order, so no frame store is needed for the labeling itself. Each accepted pixel is compared against a threshold. A foreground pixel takes the label of its west or north neighbour, or a new label if it has neither. The labels of the row above come from a one-line label memory. When a pixel joins two regions that carry different labels, an alias table is relinked so that both labels resolve to one root. Running area, X-sum and Y-sum counters, one set per label, are updated on the same cycle.

When the last pixel of the last row is accepted, the engine folds the counters of every aliased label into its root. A sequential restoring divider then computes the centroid of each label. After that the per-label results stay readable on a combinational read port until the next frame starts. A frame starts with a pixel marked start-of-frame. Each row ends with a pixel marked end-of-line, and the frame is complete when the end-of-line pixel of row `IMG_H-1` arrives.

Top module: `blob_labeler`

## Requirements
- R1: A pixel is foreground only when `pix_data` is strictly greater than `threshold`. A pixel equal to or below the threshold is background and carries label 0.
- R2: Connectivity is 4-neighbour. Pixels that touch only at a corner end up in different regions.
- R3: A foreground pixel is connected to the pixel directly above it through the stored labels of the previous row, so vertical runs form one region.
- R4: When a pixel touches two regions with different labels, the two are aliased. After the frame, exactly one label per connected region reads with `rd_root` = 1.
- R5: Every accepted foreground pixel adds exactly 1 to the area of its region, including a pixel that causes a merge. After the frame, the sum of root areas equals the foreground pixel count.
- R6: For a root label, `rd_cx` = floor(sum of x / area) and `rd_cy` = floor(sum of y / area), with x and y counted from 0 at the left column and top row. A label with area 0 reads a centroid of 0.
- R7: At most `LAB_N` labels are handed out per frame. A pixel that needs a new label after they run out is treated as background and sets `lab_overflow`, which stays high until the next accepted start-of-frame.
- R8: A valid pixel with `pix_sof` clears all tables and is pixel (0,0), even in the middle of a frame. Cycles with `pix_valid` low are ignored whatever the other inputs carry.
- R9: From the cycle after the frame's final pixel, `busy` is high until the results are ready. While it is high, all pixels are ignored, start-of-frame included. Then `frame_done` is high until the next accepted start-of-frame. `busy` and `frame_done` are never high together.
- R10: After reset, `busy`, `frame_done` and `lab_overflow` are 0, and label 0 reads area 0.
- R11: `rd_root` is 1 only for a label in 1..`LAB_N` that is its own root and has a nonzero area. Label 0 never reads as a root.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_sof | input | 1 | Pixel is the first of a frame |
| pix_eol | input | 1 | Pixel is the last of its row |
| pix_data | input | PIX_W | Pixel intensity |
| threshold | input | PIX_W | Foreground threshold |
| busy | output | 1 | Folding or dividing, input ignored |
| frame_done | output | 1 | Results readable |
| lab_overflow | output | 1 | Label supply ran out this frame |
| rd_label | input | LW | Label to read |
| rd_root | output | 1 | Read label is a live region root |
| rd_area | output | AW | Area of the read label |
| rd_cx | output | XCW | Centroid column |
| rd_cy | output | YCW | Centroid row |

## Verification
The hardest cycle is a pixel whose west and north neighbours carry different roots. In that one cycle the alias table is relinked and the region's counters are incremented, and the pixel must be counted once and land in a root that survives the fold. Images shaped like a U, a comb and a pair of columns joined late produce such merges, some of them chained. The bench judges the results without depending on which label numbers the design picks: each reference region, found by flood fill, must match one root exactly in area and centroid, and the root areas must add up to the foreground count. A start-of-frame pixel, which clears the tables in the same cycle it is counted, is covered as well, both at frame start and as a restart in the middle of a frame.

// File: rtl/blob_labeler.sv
module blob_labeler #(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480,
  parameter int PIX_W = 8,
  parameter int LAB_N = 64,
  // derived widths; keep defaults
  parameter int LW  = $clog2(LAB_N + 1),
  parameter int XCW = $clog2(IMG_W),
  parameter int YCW = $clog2(IMG_H),
  parameter int AW  = $clog2(IMG_W * IMG_H + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic             pix_sof,
  input  logic             pix_eol,
  input  logic [PIX_W-1:0] pix_data,
  input  logic [PIX_W-1:0] threshold,
  output logic             busy,
  output logic             frame_done,
  output logic             lab_overflow,
  input  logic [LW-1:0]    rd_label,
  output logic             rd_root,
  output logic [AW-1:0]    rd_area,
  output logic [XCW-1:0]   rd_cx,
  output logic [YCW-1:0]   rd_cy
);
  localparam int XW = XCW + AW;
  localparam int YW = YCW + AW;
  localparam int DW = (XW > YW) ? XW : YW;
  localparam int CW = $clog2(DW + 1);
  localparam logic [XCW-1:0] LAST_X = XCW'(IMG_W - 1);
  localparam logic [YCW-1:0] LAST_Y = YCW'(IMG_H - 1);
  localparam logic [LW:0]    TOP_LAB = (LW + 1)'(LAB_N);

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_FOLD, S_DIV, S_DONE} st_t;
  st_t st;

  logic [XCW-1:0] x_q;
  logic [YCW-1:0] y_q;
  logic [LW-1:0]  west_q;
  logic [LW:0]    next_q;
  logic           ovf_q;
  logic [LW-1:0]  line_q [IMG_W];
  logic [LW-1:0]  par_q  [LAB_N+1];
  logic [AW-1:0]  area_q [LAB_N+1];
  logic [XW-1:0]  sx_q   [LAB_N+1];
  logic [YW-1:0]  sy_q   [LAB_N+1];
  logic [XCW-1:0] cx_q   [LAB_N+1];
  logic [YCW-1:0] cy_q   [LAB_N+1];
  logic [LW-1:0]  idx_q;
  logic [CW-1:0]  dcnt_q;
  logic [AW-1:0]  dv_q, xr_q, yr_q;
  logic [DW-1:0]  xq_q, yq_q;

  // pixel acceptance and position
  wire take  = pix_valid && (st == S_RUN || ((st == S_IDLE || st == S_DONE) && pix_sof));
  wire fresh = take && pix_sof;
  wire [XCW-1:0] cx = fresh ? '0 : x_q;
  wire [YCW-1:0] cy = fresh ? '0 : y_q;
  wire fg = pix_data > threshold;

  // neighbour labels resolved through the alias table
  wire [LW-1:0] w_lab  = fresh ? '0 : west_q;
  wire [LW-1:0] n_lab  = (cy == '0) ? '0 : line_q[cx];
  wire [LW-1:0] w_root = par_q[w_lab];
  wire [LW-1:0] n_root = par_q[n_lab];
  wire [LW:0]   nxt    = fresh ? (LW + 1)'(1) : next_q;
  wire need_new = fg && w_root == '0 && n_root == '0;
  wire new_ok   = need_new && nxt <= TOP_LAB;
  wire merge    = fg && w_root != '0 && n_root != '0 && w_root != n_root;
  wire eof      = take && pix_eol && cy == LAST_Y;

  logic [LW-1:0] lab;
  always_comb begin
    if (!fg)              lab = '0;
    else if (need_new)    lab = new_ok ? nxt[LW-1:0] : '0;
    else if (w_root != 0) lab = w_root;
    else                  lab = n_root;
  end

  // restoring divider step, X and Y share the divisor
  wire last_div = dcnt_q == CW'(DW);
  wire last_idx = idx_q == LW'(LAB_N);
  wire [AW:0] xs = {xr_q, xq_q[DW-1]};
  wire [AW:0] ys = {yr_q, yq_q[DW-1]};
  wire xge = xs >= {1'b0, dv_q};
  wire yge = ys >= {1'b0, dv_q};
  wire [AW-1:0] xr_n = xge ? AW'(xs - {1'b0, dv_q}) : xs[AW-1:0];
  wire [AW-1:0] yr_n = yge ? AW'(ys - {1'b0, dv_q}) : ys[AW-1:0];
  wire [DW-1:0] xq_n = {xq_q[DW-2:0], xge};
  wire [DW-1:0] yq_n = {yq_q[DW-2:0], yge};

  always_ff @(posedge clk) begin
    if (take) line_q[cx] <= lab;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      x_q    <= '0;
      y_q    <= '0;
      west_q <= '0;
      next_q <= (LW + 1)'(1);
      ovf_q  <= 1'b0;
      idx_q  <= '0;
      dcnt_q <= '0;
      dv_q   <= '0;
      xr_q   <= '0;
      yr_q   <= '0;
      xq_q   <= '0;
      yq_q   <= '0;
      for (int i = 0; i <= LAB_N; i++) begin
        par_q[i]  <= LW'(i);
        area_q[i] <= '0;
        sx_q[i]   <= '0;
        sy_q[i]   <= '0;
        cx_q[i]   <= '0;
        cy_q[i]   <= '0;
      end
    end else if (take) begin
      west_q <= pix_eol ? '0 : lab;
      x_q    <= pix_eol ? '0 : ((cx == LAST_X) ? cx : cx + 1'b1);
      y_q    <= pix_eol ? ((cy == LAST_Y) ? cy : cy + 1'b1) : cy;
      next_q <= new_ok ? nxt + 1'b1 : nxt;
      ovf_q  <= (ovf_q && !fresh) || (need_new && !new_ok);
      st     <= eof ? S_FOLD : S_RUN;
      idx_q  <= LW'(1);
      for (int i = 0; i <= LAB_N; i++) begin
        if (fresh) begin
          par_q[i]  <= LW'(i);
          area_q[i] <= '0;
          sx_q[i]   <= '0;
          sy_q[i]   <= '0;
          cx_q[i]   <= '0;
          cy_q[i]   <= '0;
          if (lab != '0 && lab == LW'(i)) begin
            area_q[i] <= AW'(1);
            sx_q[i]   <= XW'(cx);
            sy_q[i]   <= YW'(cy);
          end
        end else begin
          if (merge && par_q[i] == n_root) par_q[i] <= w_root;
          if (lab != '0 && lab == LW'(i)) begin
            area_q[i] <= area_q[i] + 1'b1;
            sx_q[i]   <= sx_q[i] + XW'(cx);
            sy_q[i]   <= sy_q[i] + YW'(cy);
          end
        end
      end
    end else if (st == S_FOLD) begin
      for (int i = 0; i <= LAB_N; i++) begin
        if (par_q[idx_q] == LW'(i) && idx_q != LW'(i)) begin
          area_q[i] <= area_q[i] + area_q[idx_q];
          sx_q[i]   <= sx_q[i] + sx_q[idx_q];
          sy_q[i]   <= sy_q[i] + sy_q[idx_q];
        end
      end
      if (last_idx) begin
        st     <= S_DIV;
        idx_q  <= LW'(1);
        dcnt_q <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end else if (st == S_DIV) begin
      if (dcnt_q == '0) begin
        dv_q   <= area_q[idx_q];
        xr_q   <= '0;
        yr_q   <= '0;
        xq_q   <= DW'(sx_q[idx_q]);
        yq_q   <= DW'(sy_q[idx_q]);
        dcnt_q <= CW'(1);
      end else begin
        xr_q <= xr_n;
        yr_q <= yr_n;
        xq_q <= xq_n;
        yq_q <= yq_n;
        if (last_div) begin
          cx_q[idx_q] <= (dv_q == '0) ? '0 : xq_n[XCW-1:0];
          cy_q[idx_q] <= (dv_q == '0) ? '0 : yq_n[YCW-1:0];
          dcnt_q      <= '0;
          if (last_idx) st <= S_DONE;
          else          idx_q <= idx_q + 1'b1;
        end else begin
          dcnt_q <= dcnt_q + 1'b1;
        end
      end
    end
  end

  wire rd_ok = rd_label <= LW'(LAB_N);
  assign rd_area      = rd_ok ? area_q[rd_label] : '0;
  assign rd_cx        = rd_ok ? cx_q[rd_label] : '0;
  assign rd_cy        = rd_ok ? cy_q[rd_label] : '0;
  assign rd_root      = rd_ok && rd_label != '0 && par_q[rd_label] == rd_label && rd_area != '0;
  assign busy         = st == S_FOLD || st == S_DIV;
  assign frame_done   = st == S_DONE;
  assign lab_overflow = ovf_q;
endmodule

// File: rtl/blob_labeler_chk.sv
module blob_labeler_chk #(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480,
  parameter int PIX_W = 8,
  parameter int LAB_N = 64,
  parameter int LW  = $clog2(LAB_N + 1),
  parameter int XCW = $clog2(IMG_W),
  parameter int YCW = $clog2(IMG_H),
  parameter int AW  = $clog2(IMG_W * IMG_H + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pix_valid,
  input logic           pix_sof,
  input logic           busy,
  input logic           frame_done,
  input logic           lab_overflow,
  input logic [LW-1:0]  rd_label,
  input logic           rd_root,
  input logic [AW-1:0]  rd_area,
  input logic [XCW-1:0] rd_cx,
  input logic [YCW-1:0] rd_cy
);
  localparam logic [XCW-1:0] LAST_X = XCW'(IMG_W - 1);
  localparam logic [YCW-1:0] LAST_Y = YCW'(IMG_H - 1);

  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lab_overflow && !(pix_valid && pix_sof) |=> lab_overflow);

  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && frame_done));

  // R9
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_done) |-> $past(busy));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !(pix_valid && pix_sof) |=> frame_done);

  // R11
  bg_label_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_label == '0 |-> !rd_root && rd_area == '0);

  // R6
  empty_cent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && rd_area == '0 |-> rd_cx == '0 && rd_cy == '0);

  // R6
  cent_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && rd_root |-> rd_cx <= LAST_X && rd_cy <= LAST_Y);
endmodule

bind blob_labeler blob_labeler_chk #(
  .IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W), .LAB_N(LAB_N)
) chk_i (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
  .busy(busy), .frame_done(frame_done), .lab_overflow(lab_overflow),
  .rd_label(rd_label), .rd_root(rd_root), .rd_area(rd_area),
  .rd_cx(rd_cx), .rd_cy(rd_cy)
);

// File: tb/blob_labeler_tb.sv
module blob_labeler_tb_top;
  localparam int W = 8;
  localparam int H = 6;
  localparam int L = 6;
  localparam int NP = W * H;
  localparam int NV = 7;
  // {gap, threshold, rows 5..0}; bit x of a row is column x
  localparam logic [56:0] VEC [NV] = '{
    {1'b0, 8'd50,  48'h0000_0000_0000},
    {1'b0, 8'd100, 8'h01, 8'h00, 8'h7E, 8'h42, 8'h42, 8'h42},
    {1'b1, 8'd20,  8'h80, 8'h80, 8'h08, 8'h04, 8'h02, 8'h01},
    {1'b0, 8'd1,   48'hFFFF_FFFF_FFFF},
    {1'b1, 8'd128, 8'h18, 8'h81, 8'h81, 8'hFF, 8'h55, 8'h55},
    {1'b0, 8'd200, 8'h00, 8'h7E, 8'h42, 8'h4A, 8'h7E, 8'h00},
    {1'b1, 8'd77,  8'h0F, 8'h00, 8'hF0, 8'h9F, 8'h91, 8'h91}
  };

  logic clk = 0, rst_n = 0;
  logic pix_valid = 0, pix_sof = 0, pix_eol = 0;
  logic [7:0] pix_data = 0, threshold = 0;
  logic busy, frame_done, lab_overflow, rd_root;
  logic [2:0] rd_label = 0;
  logic [5:0] rd_area;
  logic [2:0] rd_cx, rd_cy;

  int total = 0, bad = 0;
  int rb_n, rb_area [NP], rb_cx [NP], rb_cy [NP], fg_cnt;

  always #5 clk = ~clk;

  blob_labeler #(.IMG_W(W), .IMG_H(H), .PIX_W(8), .LAB_N(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
    .pix_eol(pix_eol), .pix_data(pix_data), .threshold(threshold),
    .busy(busy), .frame_done(frame_done), .lab_overflow(lab_overflow),
    .rd_label(rd_label), .rd_root(rd_root), .rd_area(rd_area),
    .rd_cx(rd_cx), .rd_cy(rd_cy)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_frame(logic [47:0] m, logic [7:0] thr, bit gap, bit noise);
    threshold = thr;
    for (int y = 0; y < H; y++) begin
      for (int x = 0; x < W; x++) begin
        @(negedge clk);
        pix_valid = 1;
        pix_sof   = (x == 0 && y == 0);
        pix_eol   = (x == W - 1);
        if (m[y*W + x]) pix_data = 8'(int'(thr) + 1 + (x + y) % 3);
        else            pix_data = 8'(int'(thr) - (x + y) % 2);
        if (gap && x % 3 == 2) begin
          @(negedge clk);
          pix_valid = 0; pix_sof = 1; pix_eol = 1; pix_data = 8'hFF;
        end
      end
    end
    @(negedge clk);
    pix_valid = 0; pix_sof = 0; pix_eol = 0;
    if (noise) begin
      // R9: frame end reached; engine must be busy and deaf
      chk(busy == 1, "R9", "busy after last pixel", busy, 1);
      chk(frame_done == 0, "R9", "done while busy", frame_done, 0);
      for (int k = 0; k < 12; k++) begin
        pix_valid = 1; pix_sof = 1; pix_eol = 1; pix_data = 8'hFF; threshold = 0;
        @(negedge clk);
      end
      pix_valid = 0; pix_sof = 0; pix_eol = 0;
    end
  endtask

  task automatic build_ref(logic [47:0] m);
    int lab [NP];
    int sx [NP], sy [NP], ar [NP];
    bit changed;
    fg_cnt = 0;
    for (int p = 0; p < NP; p++) begin
      lab[p] = m[p] ? p + 1 : 0;
      sx[p] = 0; sy[p] = 0; ar[p] = 0;
      if (m[p]) fg_cnt++;
    end
    do begin
      changed = 0;
      for (int p = 0; p < NP; p++) begin
        if (lab[p] != 0) begin
          int x, y;
          x = p % W; y = p / W;
          if (x > 0     && lab[p-1] != 0 && lab[p-1] < lab[p]) begin lab[p] = lab[p-1]; changed = 1; end
          if (x < W - 1 && lab[p+1] != 0 && lab[p+1] < lab[p]) begin lab[p] = lab[p+1]; changed = 1; end
          if (y > 0     && lab[p-W] != 0 && lab[p-W] < lab[p]) begin lab[p] = lab[p-W]; changed = 1; end
          if (y < H - 1 && lab[p+W] != 0 && lab[p+W] < lab[p]) begin lab[p] = lab[p+W]; changed = 1; end
        end
      end
    end while (changed);
    for (int p = 0; p < NP; p++) begin
      if (lab[p] != 0) begin
        ar[lab[p]-1]++;
        sx[lab[p]-1] += p % W;
        sy[lab[p]-1] += p / W;
      end
    end
    rb_n = 0;
    for (int p = 0; p < NP; p++) begin
      if (ar[p] != 0) begin
        rb_area[rb_n] = ar[p];
        rb_cx[rb_n] = sx[p] / ar[p];
        rb_cy[rb_n] = sy[p] / ar[p];
        rb_n++;
      end
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (!frame_done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(frame_done == 1, "R9", "frame_done reached", frame_done, 1);
  endtask

  task automatic check_frame(int v);
    int d_area [L+1], d_cx [L+1], d_cy [L+1];
    bit d_root [L+1], used [L+1];
    int roots = 0, sum = 0;
    wait_done();
    for (int i = 0; i <= L; i++) begin
      @(negedge clk);
      rd_label = 3'(i);
      #1;
      d_root[i] = rd_root; d_area[i] = rd_area; d_cx[i] = rd_cx; d_cy[i] = rd_cy;
      used[i] = 0;
      if (rd_root) begin roots++; sum += rd_area; end
    end
    chk(roots == rb_n, "R2,R3,R4", $sformatf("root count vec %0d", v), roots, rb_n);
    chk(sum == fg_cnt, "R1,R5", $sformatf("area sum vec %0d", v), sum, fg_cnt);
    chk(lab_overflow == 0, "R7", $sformatf("no overflow vec %0d", v), lab_overflow, 0);
    for (int b = 0; b < rb_n; b++) begin
      bit found = 0;
      for (int i = 1; i <= L; i++) begin
        if (!found && !used[i] && d_root[i] && d_area[i] == rb_area[b] &&
            d_cx[i] == rb_cx[b] && d_cy[i] == rb_cy[b]) begin
          used[i] = 1; found = 1;
        end
      end
      chk(found, "R6", $sformatf("region %0d area %0d cx %0d cy %0d vec %0d",
          b, rb_area[b], rb_cx[b], rb_cy[b], v), int'(found), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    // R10 reset state
    chk(busy == 0, "R10", "busy after reset", busy, 0);
    chk(frame_done == 0, "R10", "done after reset", frame_done, 0);
    chk(lab_overflow == 0, "R10", "overflow after reset", lab_overflow, 0);
    chk(rd_area == 0 && rd_root == 0, "R10,R11", "label 0 after reset", rd_area, 0);

    // table of frames
    for (int v = 0; v < NV; v++) begin
      build_ref(VEC[v][47:0]);
      drive_frame(VEC[v][47:0], VEC[v][55:48], VEC[v][56], 0);
      check_frame(v);
    end

    // R9: pixels during fold and divide are ignored
    build_ref(VEC[1][47:0]);
    drive_frame(VEC[1][47:0], VEC[1][55:48], 0, 1);
    check_frame(101);

    // R9/R8: accepted sof clears frame_done; a mid-frame sof restarts
    @(negedge clk);
    pix_valid = 1; pix_sof = 1; pix_eol = 0; pix_data = 8'hFF; threshold = 8'd10;
    @(negedge clk);
    pix_valid = 0; pix_sof = 0;
    chk(frame_done == 0, "R9", "done cleared by sof", frame_done, 1'b0);
    chk(busy == 0, "R9", "busy while streaming", busy, 0);
    @(negedge clk);
    pix_valid = 1; pix_data = 8'hFF;
    @(negedge clk);
    pix_valid = 0;
    build_ref(VEC[5][47:0]);
    drive_frame(VEC[5][47:0], VEC[5][55:48], 0, 0);
    check_frame(105);

    // R7: eight isolated pixels against six labels
    drive_frame({8'h00, 8'h00, 8'h00, 8'h55, 8'h00, 8'h55}, 8'd60, 0, 0);
    wait_done();
    begin
      int roots = 0, sum = 0;
      for (int i = 0; i <= L; i++) begin
        @(negedge clk);
        rd_label = 3'(i);
        #1;
        if (rd_root) begin roots++; sum += rd_area; end
      end
      chk(lab_overflow == 1, "R7", "overflow raised", lab_overflow, 1);
      chk(roots == L, "R7", "labeled regions", roots, L);
      chk(sum == L, "R7", "counted pixels", sum, L);
    end
    // R7: flag clears only with the next frame
    build_ref(VEC[1][47:0]);
    drive_frame(VEC[1][47:0], VEC[1][55:48], 1, 0);
    check_frame(201);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule